// File: doc/BRIEF.md
# Banked Program ROM Address Mapper with Nibble Table Reader

This block turns a 13-bit logical program address into a 14-bit physical address for a 16K x 8 program ROM that is split into four 4K banks. The lower half of the logical space always lands in physical bank 0. The upper half is a window whose physical bank depends on a 2-bit bank register. Software writes that register through a plain write strobe.

A second path reads constant data out of the same ROM. A 12-bit table pointer is loaded one nibble at a time through three lane strobes. Table reads always go through the upper, bank-switched window. A read request returns either the low or the high nibble of the addressed byte. A high-nibble read also advances the pointer by one. Requests use a valid/ready handshake and results are returned on a valid/ready handshake.

Back-pressure rules:
- A request is taken only in a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever no result is pending or the pending result is being taken in that same cycle.
- A result stays valid and unchanged until `res_ready` takes it.

Top module: `rom_window_mapper`

## Requirements
- R1: When `pc[12]` is 0, `fetch_addr` is `{2'b00, pc[11:0]}`, whatever the bank register holds.
- R2: When `pc[12]` is 1, `fetch_addr[11:0]` equals `pc[11:0]`, and `fetch_addr[13:12]` depends on the bank register: 1 for a register value of 0, 2 for a value of 1, and 3 for a value of 2.
- R3: A bank register value of 3 selects physical bank 3, the same bank as a value of 2.
- R4: After reset the bank register is 0, the table pointer is 000h (`tbl_addr` = 1000h), and `res_valid` is low.
- R5: A pulse on `ptr_load[i]` replaces only pointer bits [4i+3:4i] with `ptr_nib`. Lane 0 is bits 3:0, lane 1 is bits 7:4 and lane 2 is bits 11:8.
- R6: An accepted request with `req_hi`=0 returns bits 3:0 of the ROM byte at `tbl_addr` and leaves the pointer unchanged.
- R7: An accepted request with `req_hi`=1 returns bits 7:4 of that byte and then increments the pointer by one.
- R8: `tbl_addr` is `{mapped upper bank, pointer}`, using the same mapping as R2 and R3. With bank 0 and pointer 777h it addresses 1777h, so a byte 56h reads as 6h (low) and then 5h (high).
- R9: A high read at pointer FFFh wraps the pointer to 000h and leaves the bank register unchanged.
- R10: `req_ready` = `!res_valid || res_ready`. A pending result holds its data. A request that is not accepted changes nothing.
- R11: When a nibble load and an accepted read fall in the same cycle, the read uses the old pointer and the load wins, so no increment happens. A bank write in the same cycle as a read takes effect after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc | input | 13 | Logical program address |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 2 | New bank register value |
| ptr_load | input | 3 | Per-nibble pointer load strobes, lane 0 = low nibble |
| ptr_nib | input | 4 | Nibble loaded by `ptr_load` |
| req_valid | input | 1 | Table read request valid |
| req_ready | output | 1 | Table read request ready |
| req_hi | input | 1 | 0 = low nibble read, 1 = high nibble read with increment |
| res_valid | output | 1 | Read result valid |
| res_ready | input | 1 | Read result taken |
| res_data | output | 4 | Read result nibble |
| fetch_addr | output | 14 | Physical ROM address for instruction fetch |
| tbl_addr | output | 14 | Physical ROM address for table reads |
| tbl_rdata | input | 8 | ROM byte at `tbl_addr` (combinational) |

## Verification
Two functions can fall in the same cycle: a pointer nibble load and an accepted high-nibble read, which would also move the pointer. The bench provokes this by raising a lane strobe and a high read request in the same cycle. It then checks two things: that the returned nibble comes from the byte at the old pointer, and that the new pointer equals the old one with only the loaded lane replaced. A bank write is also issued in the same cycle as a read, and the bench checks that the read still uses the old bank and that the new bank appears afterwards on `tbl_addr`.

// File: rtl/rwm_pkg.sv
package rwm_pkg;
  typedef enum logic {NIB_LO = 1'b0, NIB_HI = 1'b1} nib_sel_e;
endpackage

// File: rtl/rwm_addr_map.sv
module rwm_addr_map #(
  parameter int LOG_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic [LOG_W-1:0]        log_addr,
  input  logic [BANK_W-1:0]       bank_sel,
  output logic [LOG_W+BANK_W-2:0] phys_addr
);
  localparam int OFF_W = LOG_W - 1;
  localparam logic [BANK_W-1:0] TOP_BANK = '1;

  logic [BANK_W-1:0] phys_bank;

  // Upper window: bank_sel + 1, saturating at the top bank.
  always_comb begin
    if (!log_addr[LOG_W-1])
      phys_bank = '0;
    else if (bank_sel == TOP_BANK)
      phys_bank = TOP_BANK;
    else
      phys_bank = bank_sel + 1'b1;
  end

  assign phys_addr = {phys_bank, log_addr[OFF_W-1:0]};
endmodule

// File: rtl/rwm_table_ptr.sv
module rwm_table_ptr #(
  parameter int PTR_W = 12,
  parameter int NIB_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PTR_W/NIB_W-1:0] load,
  input  logic [NIB_W-1:0]       nib,
  input  logic                   advance,
  output logic [PTR_W-1:0]       ptr
);
  localparam int LANES = PTR_W / NIB_W;

  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_nxt;
  logic             any_load;

  assign any_load = |load;
  // A load in the same cycle drops the increment.
  assign ptr_inc  = (advance && !any_load) ? ptr + 1'b1 : ptr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ptr_nxt[g*NIB_W +: NIB_W] = load[g] ? nib : ptr_inc[g*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end
endmodule

// File: rtl/rwm_nib_reader.sv
module rwm_nib_reader
  import rwm_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  nib_sel_e           req_sel,
  input  logic [2*NIB_W-1:0] byte_in,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [NIB_W-1:0]   res_data,
  output logic               take,
  output logic               take_hi
);
  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;
  assign take_hi   = take && (req_sel == NIB_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_data  <= (req_sel == NIB_HI) ? byte_in[2*NIB_W-1:NIB_W] : byte_in[NIB_W-1:0];
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rom_window_mapper.sv
module rom_window_mapper
  import rwm_pkg::*;
#(
  parameter int LOG_W  = 13,
  parameter int BANK_W = 2,
  parameter int NIB_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LOG_W-1:0]          pc,
  input  logic                      bank_we,
  input  logic [BANK_W-1:0]         bank_wdata,
  input  logic [(LOG_W-1)/NIB_W-1:0] ptr_load,
  input  logic [NIB_W-1:0]          ptr_nib,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_hi,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [NIB_W-1:0]          res_data,
  output logic [LOG_W+BANK_W-2:0]   fetch_addr,
  output logic [LOG_W+BANK_W-2:0]   tbl_addr,
  input  logic [2*NIB_W-1:0]        tbl_rdata
);
  localparam int PTR_W = LOG_W - 1;

  logic [BANK_W-1:0] bank_q;
  logic [PTR_W-1:0]  ptr;
  logic              take;
  logic              take_hi;
  nib_sel_e          sel;

  assign sel = req_hi ? NIB_HI : NIB_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_we) bank_q <= bank_wdata;
  end

  rwm_addr_map #(.LOG_W(LOG_W), .BANK_W(BANK_W)) u_fetch_map (
    .log_addr(pc), .bank_sel(bank_q), .phys_addr(fetch_addr)
  );

  rwm_addr_map #(.LOG_W(LOG_W), .BANK_W(BANK_W)) u_tbl_map (
    .log_addr({1'b1, ptr}), .bank_sel(bank_q), .phys_addr(tbl_addr)
  );

  rwm_table_ptr #(.PTR_W(PTR_W), .NIB_W(NIB_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .nib(ptr_nib),
    .advance(take_hi), .ptr(ptr)
  );

  rwm_nib_reader #(.NIB_W(NIB_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(sel), .byte_in(tbl_rdata), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .take(take), .take_hi(take_hi)
  );
endmodule

// File: rtl/rwm_checker.sv
module rwm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] pc,
  input logic [2:0]  ptr_load,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_hi,
  input logic        res_valid,
  input logic        res_ready,
  input logic [3:0]  res_data,
  input logic [13:0] fetch_addr,
  input logic [13:0] tbl_addr
);
  a_r1_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    !pc[12] |-> fetch_addr == {2'b00, pc[11:0]});

  a_r2_upper_window: assert property (@(posedge clk) disable iff (!rst_n)
    pc[12] |-> (fetch_addr[13:12] != 2'b00) && (fetch_addr[11:0] == pc[11:0]));

  a_r8_table_never_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_addr[13:12] != 2'b00);

  a_r6_low_read_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_hi && ptr_load == 3'b000)
      |=> tbl_addr[11:0] == $past(tbl_addr[11:0]));

  a_r7_high_read_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_hi && ptr_load == 3'b000)
      |=> tbl_addr[11:0] == $past(tbl_addr[11:0]) + 12'd1);

  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data));

  a_r10_idle_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && ptr_load == 3'b000)
      |=> tbl_addr[11:0] == $past(tbl_addr[11:0]));
endmodule

bind rom_window_mapper rwm_checker u_rwm_checker (
  .clk(clk), .rst_n(rst_n), .pc(pc), .ptr_load(ptr_load),
  .req_valid(req_valid), .req_ready(req_ready), .req_hi(req_hi),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .fetch_addr(fetch_addr), .tbl_addr(tbl_addr)
);

// File: tb/rom_window_mapper_tb.sv
module rom_window_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] pc = '0;
  logic        bank_we = 1'b0;
  logic [1:0]  bank_wdata = '0;
  logic [2:0]  ptr_load = '0;
  logic [3:0]  ptr_nib = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_hi = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [3:0]  res_data;
  logic [13:0] fetch_addr;
  logic [13:0] tbl_addr;
  logic [7:0]  tbl_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [13:0] a);
    if (a == 14'h1777) return 8'h56;
    return a[7:0] ^ {a[13:10], a[11:8]} ^ 8'h3C;
  endfunction

  assign tbl_rdata = rom_fn(tbl_addr);

  rom_window_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .pc(pc), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .ptr_load(ptr_load), .ptr_nib(ptr_nib), .req_valid(req_valid), .req_ready(req_ready),
    .req_hi(req_hi), .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .fetch_addr(fetch_addr), .tbl_addr(tbl_addr), .tbl_rdata(tbl_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_bank(input logic [1:0] b);
    @(negedge clk); bank_we = 1'b1; bank_wdata = b;
    @(negedge clk); bank_we = 1'b0;
  endtask

  task automatic load_ptr(input logic [11:0] p);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ptr_load = 3'b001 << i; ptr_nib = p[i*4 +: 4];
    end
    @(negedge clk); ptr_load = '0;
  endtask

  // Issues one read; on return it is the negedge after the accepting edge.
  task automatic tbl_read(input bit hi);
    @(negedge clk); req_valid = 1'b1; req_hi = hi;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R4 bank/ptr reset tbl_addr", tbl_addr, 14'h1000);
    chk("R4 res_valid low", res_valid, 0);
    pc = 13'h1234; #1;
    chk("R4 reset bank maps upper to 1", fetch_addr, 14'h1234);
  endtask

  task automatic t_windows;
    for (int b = 0; b < 4; b++) begin
      set_bank(b[1:0]);
      pc = 13'h0ABC; #1;
      chk("R1 low window bank 0", fetch_addr, 14'h0ABC);
      pc = 13'h1ABC; #1;
      if (b == 3) chk("R3 bank reg 3 -> bank 3", fetch_addr, 14'h3ABC);
      else        chk("R2 upper window bank", fetch_addr, {b[1:0] + 2'd1, 12'hABC});
    end
  endtask

  task automatic t_ptr_lanes;
    load_ptr(12'h5A3);
    @(negedge clk); ptr_load = 3'b010; ptr_nib = 4'hE;
    @(negedge clk); ptr_load = '0;
    chk("R5 lane1 only", tbl_addr[11:0], 12'h5E3);
  endtask

  task automatic t_example;
    set_bank(2'b00);
    load_ptr(12'h777);
    chk("R8 addr 1777", tbl_addr, 14'h1777);
    tbl_read(0);
    chk("R6 low nibble 6", res_data, 4'h6);
    chk("R6 ptr unchanged", tbl_addr, 14'h1777);
    tbl_read(1);
    chk("R7 high nibble 5", res_data, 4'h5);
    chk("R7 ptr incremented", tbl_addr, 14'h1778);
    set_bank(2'b10);
    chk("R8 bank 2 maps table to 3", tbl_addr, 14'h3778);
    tbl_read(0);
    chk("R6 low nibble bank3", res_data, {28'd0, rom_fn(14'h3778) & 8'h0F});
  endtask

  task automatic t_wrap;
    set_bank(2'b01);
    load_ptr(12'hFFF);
    tbl_read(1);
    chk("R9 high nibble at FFF", res_data, {28'd0, rom_fn(14'h2FFF) >> 4});
    chk("R9 wrap to 000, bank kept", tbl_addr, 14'h2000);
  endtask

  task automatic t_backpressure;
    load_ptr(12'h040);
    @(negedge clk); res_ready = 1'b0;
    tbl_read(0);
    chk("R10 result valid", res_valid, 1);
    chk("R10 low data", res_data, {28'd0, rom_fn(14'h2040) & 8'h0F});
    chk("R10 not ready while held", req_ready, 0);
    req_valid = 1'b1; req_hi = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 refused req no ptr move", tbl_addr, 14'h2040);
    chk("R10 data held", res_data, {28'd0, rom_fn(14'h2040) & 8'h0F});
    res_ready = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    chk("R10 accepted on release", res_data, {28'd0, rom_fn(14'h2040) >> 4});
    chk("R10 ptr stepped after release", tbl_addr, 14'h2041);
  endtask

  task automatic t_collision;
    set_bank(2'b00);
    load_ptr(12'h123);
    @(negedge clk); req_valid = 1'b1; req_hi = 1'b1; ptr_load = 3'b001; ptr_nib = 4'h9;
    bank_we = 1'b1; bank_wdata = 2'b01;
    @(negedge clk); req_valid = 1'b0; ptr_load = '0; bank_we = 1'b0;
    chk("R11 read uses old ptr and bank", res_data, {28'd0, rom_fn(14'h1123) >> 4});
    chk("R11 load wins, no increment, new bank", tbl_addr, 14'h2129);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_windows();
    t_ptr_lanes();
    t_example();
    t_wrap();
    t_backpressure();
    t_collision();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule